// File: doc/BRIEF.md
# Priority Peripheral Pin Crossbar

This block places the signals of a fixed set of on-chip digital peripherals onto a bank of 16 physical I/O pins, organised as two ports of eight. Software-style configuration arrives as plain level inputs: a global enable, one enable bit per peripheral resource, a per-pin skip mask, and a select between three-wire and four-wire SPI. From these the block works out, combinationally, which function code each pin carries. It then steers each pin's output value and output enable from the owning peripheral signal, and each pin's input value back to that signal.

Allocation is greedy and follows a fixed priority. The asynchronous serial port is special: its transmit and receive signals sit on two fixed pins of the first port. Every other resource takes the lowest pins that are still free. A multi-signal resource is placed whole or not at all. When pins run short, that resource and every one after it are left unplaced and flagged. Pins that receive no function remain general-purpose I/O, driven from the GPIO inputs. A one-cycle registered copy of the pin function map is provided for downstream logic that wants a clean, flopped view.

Every pin is a configuration or pass-through level, so there is no valid/ready handshake. All ports are plain control and data levels that may change in any cycle.

Top module: `pin_xbar`

## Requirements
- R1: While `xbar_en` and `res_en[0]` (serial port) are high, pin 4 carries code 1 (serial TX) and pin 5 carries code 2 (serial RX), whatever `skip_mask` holds. The other resources never receive those two pins.
- R2: The other resources are placed in this priority order: `res_en[1]` SPI (SCK=3, MISO=4, MOSI=5, NSS=6), `res_en[2]` two-wire bus (SDA=7, SCL=8), `res_en[3]` comparator=9, `res_en[4]` clock output=10, `res_en[5..8]` capture/compare channels 0..3 = codes 11..14. Each signal goes to the lowest-numbered free pin, in signal order, and no code appears on more than one pin.
- R3: A pin whose `skip_mask` bit is set never receives a code from 3 to 14. It carries code 0 unless R1 applies to it.
- R4: While `res_en[0]` is low, pins 4 and 5 are ordinary free pins for the other resources.
- R5: The NSS signal (code 6) is placed only when `spi_4w` is high. When `spi_4w` is low, SPI uses three pins and code 6 appears nowhere.
- R6: A resource is placed only if all of its signals fit in the remaining free pins. Otherwise it is not placed, nor is any enabled resource of lower priority, and `res_ovf` is set for each such enabled resource. `res_ovf[0]` is always 0.
- R7: While `xbar_en` is low, every pin carries code 0, `pin_oe` is all zero, and `res_ovf` is zero.
- R8: A pin with code c>0 drives `pin_out`/`pin_oe` from `sig_out[c-1]`/`sig_oe[c-1]`. A pin with code 0 drives `gpio_out[p]` and `gpio_oe[p] & xbar_en`.
- R9: `sig_in[c-1]` equals `pin_in` of the pin carrying code c. It is 0 when no pin carries code c.
- R10: `pin_assigned[p]` is high exactly when pin p carries a nonzero code.
- R11: `pin_func_q` is reset to all zero by active-low `rst_n`. After reset, on each rising clock edge it takes the value that `pin_func` had before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered map |
| rst_n | input | 1 | Asynchronous active-low reset |
| xbar_en | input | 1 | Global crossbar enable |
| res_en | input | 9 | Per-resource enable, bit order as in R1/R2 |
| spi_4w | input | 1 | 1 = four-wire SPI (NSS routed) |
| skip_mask | input | 16 | Per-pin skip bit |
| pin_func | output | 64 | 4-bit function code per pin, pin p at bits 4p+3:4p |
| pin_assigned | output | 16 | Pin holds a nonzero code |
| pin_func_q | output | 64 | Registered copy of pin_func |
| res_ovf | output | 9 | Resource did not fit |
| sig_out | input | 14 | Peripheral output value, bit c-1 for code c |
| sig_oe | input | 14 | Peripheral output enable, bit c-1 for code c |
| sig_in | output | 14 | Pin input routed to peripheral, bit c-1 for code c |
| gpio_out | input | 16 | GPIO output value per pin |
| gpio_oe | input | 16 | GPIO output enable per pin |
| pin_in | input | 16 | Pad input values |
| pin_out | output | 16 | Pad output values |
| pin_oe | output | 16 | Pad output enables |

## Verification
A corrupted free-pin index or rank count shows up at `pin_func` in the same cycle as the configuration change. It appears as a code on the wrong pin, a duplicated code, or a resource that goes missing. It reaches `pin_func_q` one clock later. A wrong placement decision also flips `res_ovf` and redirects `pin_out`, `pin_oe` and `sig_in` in that cycle. Comparing every port against an independent greedy allocator, after each configuration change, therefore exposes a fault without delay.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int FW   = 4;
  localparam int NSIG = 14;
  localparam int NRES = 9;

  typedef enum logic [FW-1:0] {
    F_GPIO = 4'd0, F_U0TX = 4'd1, F_U0RX = 4'd2,
    F_SCK = 4'd3, F_MISO = 4'd4, F_MOSI = 4'd5, F_NSS = 4'd6,
    F_SDA = 4'd7, F_SCL = 4'd8, F_CMP = 4'd9, F_CLKO = 4'd10,
    F_CC0 = 4'd11, F_CC1 = 4'd12, F_CC2 = 4'd13, F_CC3 = 4'd14
  } func_e;

  localparam int RS_SER = 0;
  localparam int RS_SPI = 1;

  // resource index owning signal code s (1..NSIG)
  function automatic int sig_res(input int s);
    if (s <= 2)      return 0;
    else if (s <= 6) return 1;
    else if (s <= 8) return 2;
    else             return s - 6;
  endfunction
endpackage

// File: rtl/xbar_alloc.sv
module xbar_alloc
  import xbar_pkg::*;
#(
  parameter int NPIN = 16,
  parameter int UTX  = 4,
  parameter int URX  = 5
) (
  input  logic                 xbar_en,
  input  logic [NRES-1:0]      res_en,
  input  logic                 spi_4w,
  input  logic [NPIN-1:0]      skip,
  output logic [NPIN*FW-1:0]   pin_func,
  output logic [NRES-1:0]      res_ovf
);
  localparam int CW = $clog2(NPIN + NSIG + 1);

  logic [NPIN-1:0] rsv, freep;
  logic [CW-1:0]   nfree, prun, srun;
  logic [CW-1:0]   fidx [NPIN];
  logic [CW-1:0]   rank [NSIG+1];
  logic [CW-1:0]   cum  [NRES];
  logic [NSIG:0]   act;
  logic [NRES-1:0] placed;

  // free pins and their ordinal among free pins
  always_comb begin
    rsv = '0;
    if (res_en[RS_SER]) begin
      rsv[UTX] = 1'b1;
      rsv[URX] = 1'b1;
    end
    freep = ~skip & ~rsv;
    prun  = '0;
    for (int p = 0; p < NPIN; p++) begin
      fidx[p] = prun;
      if (freep[p]) prun = prun + 1'b1;
    end
    nfree = prun;
  end

  // rank of each active signal and cumulative demand per resource
  always_comb begin
    srun = '0;
    act  = '0;
    for (int r = 0; r < NRES; r++) cum[r] = '0;
    for (int s = 0; s <= NSIG; s++) begin
      rank[s] = srun;
      if (s >= int'(F_SCK)) begin
        act[s] = res_en[sig_res(s)] && !(s == int'(F_NSS) && !spi_4w);
        if (act[s]) begin
          srun = srun + 1'b1;
          cum[sig_res(s)] = srun;
        end
      end
    end
    for (int r = 0; r < NRES; r++) begin
      placed[r]  = res_en[r] && (cum[r] <= nfree);
      res_ovf[r] = xbar_en && res_en[r] && (cum[r] > nfree);
    end
  end

  // per-pin selection: free pin k takes active signal of rank k
  always_comb begin
    pin_func = '0;
    if (xbar_en) begin
      for (int p = 0; p < NPIN; p++) begin
        if (res_en[RS_SER] && p == UTX)
          pin_func[p*FW +: FW] = F_U0TX;
        else if (res_en[RS_SER] && p == URX)
          pin_func[p*FW +: FW] = F_U0RX;
        else if (freep[p]) begin
          for (int s = int'(F_SCK); s <= NSIG; s++)
            if (act[s] && placed[sig_res(s)] && rank[s] == fidx[p])
              pin_func[p*FW +: FW] = FW'(s);
        end
      end
    end
  end
endmodule

// File: rtl/xbar_route.sv
module xbar_route
  import xbar_pkg::*;
#(
  parameter int NPIN = 16
) (
  input  logic                 xbar_en,
  input  logic [NPIN*FW-1:0]   pin_func,
  input  logic [NSIG-1:0]      sig_out,
  input  logic [NSIG-1:0]      sig_oe,
  output logic [NSIG-1:0]      sig_in,
  input  logic [NPIN-1:0]      gpio_out,
  input  logic [NPIN-1:0]      gpio_oe,
  input  logic [NPIN-1:0]      pin_in,
  output logic [NPIN-1:0]      pin_out,
  output logic [NPIN-1:0]      pin_oe
);
  logic [FW-1:0] f;

  always_comb begin
    pin_out = '0;
    pin_oe  = '0;
    sig_in  = '0;
    f       = '0;
    for (int p = 0; p < NPIN; p++) begin
      f = pin_func[p*FW +: FW];
      if (f == '0 || int'(f) > NSIG) begin
        pin_out[p] = gpio_out[p];
        pin_oe[p]  = gpio_oe[p] & xbar_en;
      end else begin
        pin_out[p]     = sig_out[int'(f) - 1];
        pin_oe[p]      = sig_oe[int'(f) - 1];
        sig_in[int'(f) - 1] = pin_in[p];
      end
    end
  end
endmodule

// File: rtl/pin_xbar.sv
module pin_xbar
  import xbar_pkg::*;
#(
  parameter int NPORT   = 2,
  parameter int PORT_W  = 8,
  parameter int UTX_PIN = 4,
  parameter int URX_PIN = 5,
  localparam int NPIN   = NPORT * PORT_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 xbar_en,
  input  logic [NRES-1:0]      res_en,
  input  logic                 spi_4w,
  input  logic [NPIN-1:0]      skip_mask,
  output logic [NPIN*FW-1:0]   pin_func,
  output logic [NPIN-1:0]      pin_assigned,
  output logic [NPIN*FW-1:0]   pin_func_q,
  output logic [NRES-1:0]      res_ovf,
  input  logic [NSIG-1:0]      sig_out,
  input  logic [NSIG-1:0]      sig_oe,
  output logic [NSIG-1:0]      sig_in,
  input  logic [NPIN-1:0]      gpio_out,
  input  logic [NPIN-1:0]      gpio_oe,
  input  logic [NPIN-1:0]      pin_in,
  output logic [NPIN-1:0]      pin_out,
  output logic [NPIN-1:0]      pin_oe
);
  xbar_alloc #(.NPIN(NPIN), .UTX(UTX_PIN), .URX(URX_PIN)) u_alloc (
    .xbar_en  (xbar_en),
    .res_en   (res_en),
    .spi_4w   (spi_4w),
    .skip     (skip_mask),
    .pin_func (pin_func),
    .res_ovf  (res_ovf)
  );

  xbar_route #(.NPIN(NPIN)) u_route (
    .xbar_en  (xbar_en),
    .pin_func (pin_func),
    .sig_out  (sig_out),
    .sig_oe   (sig_oe),
    .sig_in   (sig_in),
    .gpio_out (gpio_out),
    .gpio_oe  (gpio_oe),
    .pin_in   (pin_in),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe)
  );

  for (genvar p = 0; p < NPIN; p++) begin : g_asg
    assign pin_assigned[p] = |pin_func[p*FW +: FW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_func_q <= '0;
    else        pin_func_q <= pin_func;
  end
endmodule

// File: rtl/pin_xbar_chk.sv
module pin_xbar_chk
  import xbar_pkg::*;
#(
  parameter int NPIN = 16,
  parameter int UTX  = 4,
  parameter int URX  = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 xbar_en,
  input logic [NRES-1:0]      res_en,
  input logic                 spi_4w,
  input logic [NPIN-1:0]      skip_mask,
  input logic [NPIN*FW-1:0]   pin_func,
  input logic [NPIN*FW-1:0]   pin_func_q,
  input logic [NRES-1:0]      res_ovf,
  input logic [NPIN-1:0]      pin_oe
);
  // R7
  xoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xbar_en |-> (pin_oe == '0 && pin_func == '0 && res_ovf == '0));

  // R1
  ser_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xbar_en && res_en[RS_SER]) |->
      (pin_func[UTX*FW +: FW] == F_U0TX && pin_func[URX*FW +: FW] == F_U0RX));

  // R11
  regq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pin_func_q == $past(pin_func));

  // R6
  ovf_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|res_ovf) |-> (res_ovf[0] == 1'b0 && res_ovf[NRES-1] == res_en[NRES-1]));

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    // R3
    skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (skip_mask[p] && !(res_en[RS_SER] && (p == UTX || p == URX)))
        |-> pin_func[p*FW +: FW] == F_GPIO);
    // R5
    nss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !spi_4w |-> pin_func[p*FW +: FW] != F_NSS);
  end

  for (genvar c = 1; c <= NSIG; c++) begin : g_code
    logic [NPIN-1:0] hit;
    always_comb
      for (int p = 0; p < NPIN; p++) hit[p] = (pin_func[p*FW +: FW] == FW'(c));
    // R2
    uniq_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit));
  end
endmodule

bind pin_xbar pin_xbar_chk #(.NPIN(NPIN), .UTX(UTX_PIN), .URX(URX_PIN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .xbar_en    (xbar_en),
  .res_en     (res_en),
  .spi_4w     (spi_4w),
  .skip_mask  (skip_mask),
  .pin_func   (pin_func),
  .pin_func_q (pin_func_q),
  .res_ovf    (res_ovf),
  .pin_oe     (pin_oe)
);

// File: tb/sim_pin_xbar.sv
module sim_pin_xbar;
  localparam int NPIN = 16;
  localparam int NSIG = 14;
  localparam int NRES = 9;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n, xbar_en, spi_4w;
  logic [NRES-1:0]   res_en, res_ovf;
  logic [NPIN-1:0]   skip_mask, pin_assigned, gpio_out, gpio_oe, pin_in, pin_out, pin_oe;
  logic [NPIN*4-1:0] pin_func, pin_func_q;
  logic [NSIG-1:0]   sig_out, sig_oe, sig_in;

  pin_xbar u0 (
    .clk(clk), .rst_n(rst_n), .xbar_en(xbar_en), .res_en(res_en), .spi_4w(spi_4w),
    .skip_mask(skip_mask), .pin_func(pin_func), .pin_assigned(pin_assigned),
    .pin_func_q(pin_func_q), .res_ovf(res_ovf), .sig_out(sig_out), .sig_oe(sig_oe),
    .sig_in(sig_in), .gpio_out(gpio_out), .gpio_oe(gpio_oe), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  int nchk = 0, nbad = 0, cyc = 0;
  bit done = 0;
  logic [63:0] exp_fm;
  logic [8:0]  exp_ov;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  endtask

  // independent greedy reference allocator
  function automatic void ref_map(input bit xen, input logic [8:0] en, input bit w4,
                                  input logic [15:0] sk, output logic [63:0] fm,
                                  output logic [8:0] ov);
    logic [15:0] taken;
    int need, first, nfree;
    bit stop;
    fm = '0; ov = '0; taken = sk; stop = 0;
    if (!xen) return;
    if (en[0]) begin
      fm[19:16] = 4'd1; fm[23:20] = 4'd2; taken[4] = 1; taken[5] = 1;
    end
    for (int r = 1; r < 9; r++) begin
      if (!en[r]) continue;
      need  = (r == 1) ? (w4 ? 4 : 3) : (r == 2) ? 2 : 1;
      first = (r == 1) ? 3 : (r == 2) ? 7 : r + 6;
      nfree = 16 - $countones(taken);
      if (stop || nfree < need) begin
        ov[r] = 1; stop = 1; continue;
      end
      for (int k = 0; k < need; k++) begin
        for (int p = 0; p < 16; p++) begin
          if (!taken[p]) begin
            fm[p*4 +: 4] = 4'(first + k); taken[p] = 1; break;
          end
        end
      end
    end
  endfunction

  task automatic apply_vec(input bit xen, input logic [8:0] en, input bit w4, input logic [15:0] sk);
    logic [15:0] eo, eoe, ea;
    logic [13:0] ei;
    logic [3:0]  f;
    @(negedge clk);
    xbar_en = xen; res_en = en; spi_4w = w4; skip_mask = sk;
    sig_out = 14'($urandom); sig_oe = 14'($urandom);
    gpio_out = 16'($urandom); gpio_oe = 16'($urandom); pin_in = 16'($urandom);
    ref_map(xen, en, w4, sk, exp_fm, exp_ov);
    eo = '0; eoe = '0; ea = '0; ei = '0;
    for (int p = 0; p < 16; p++) begin
      f = exp_fm[p*4 +: 4];
      ea[p] = (f != 0);
      if (f == 0) begin eo[p] = gpio_out[p]; eoe[p] = gpio_oe[p] & xen; end
      else begin eo[p] = sig_out[f-1]; eoe[p] = sig_oe[f-1]; ei[f-1] = pin_in[p]; end
    end
    #1;
    chk(pin_func == exp_fm, "R2 map", pin_func, exp_fm);
    chk(res_ovf == exp_ov, "R6 overflow", 64'(res_ovf), 64'(exp_ov));
    chk(pin_assigned == ea, "R10 assigned", 64'(pin_assigned), 64'(ea));
    chk(pin_out == eo && pin_oe == eoe, "R8 out/oe", {pin_out, pin_oe}, {eo, eoe});
    chk(sig_in == ei, "R9 in", 64'(sig_in), 64'(ei));
    @(posedge clk); #1;
    chk(pin_func_q == exp_fm, "R11 reg", pin_func_q, exp_fm);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        nchk++; nbad++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed_0c3a));
    rst_n = 0; xbar_en = 1; res_en = '1; spi_4w = 1; skip_mask = '0;
    sig_out = '0; sig_oe = '0; gpio_out = '0; gpio_oe = '0; pin_in = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(pin_func_q == '0, "R11 reset", pin_func_q, 64'd0);
    @(negedge clk); rst_n = 1;

    // R1 + R3: serial port fixed even on skipped pins; all else skipped
    apply_vec(1, 9'h001, 0, 16'hFFFF);
    chk(pin_func[19:16] == 4'd1 && pin_func[23:20] == 4'd2, "R1 fixed pins",
        64'(pin_func[23:16]), 64'h21);
    chk(pin_func[15:0] == '0 && pin_func[63:24] == '0, "R3 skipped stay gpio",
        pin_func, 64'h0000_0000_0021_0000);

    // R4: serial off, pins 4/5 reused (SPI 3-wire + two-wire bus)
    apply_vec(1, 9'h006, 0, 16'h0000);
    chk(pin_func[19:16] == 4'd8, "R4 pin4 reused", 64'(pin_func[19:16]), 64'd8);
    // R5: three-wire has no NSS code 6 at pin 3
    chk(pin_func[15:12] == 4'd7, "R5 three-wire no NSS", 64'(pin_func[15:12]), 64'd7);
    apply_vec(1, 9'h006, 1, 16'h0000);
    chk(pin_func[15:12] == 4'd6, "R5 four-wire NSS", 64'(pin_func[15:12]), 64'd6);

    // R6: four free pins, SPI fits, the rest overflow
    apply_vec(1, 9'h1FF, 1, 16'hFFC0);
    chk(res_ovf == 9'h1FC, "R6 tail overflow", 64'(res_ovf), 64'h1FC);
    // R6: SPI too big with three free pins, everything lower also fails
    apply_vec(1, 9'h1FF, 1, 16'hFFC8);
    chk(res_ovf == 9'h1FE && pin_func[15:0] == '0, "R6 atomic",
        {res_ovf, pin_func[15:0]}, {9'h1FE, 16'h0});

    // R7: crossbar off
    apply_vec(0, 9'h1FF, 1, 16'h0000);
    chk(pin_oe == '0 && pin_func == '0, "R7 disabled", {pin_oe, pin_func[47:0]}, 64'd0);

    // R2: everything enabled, no skips
    apply_vec(1, 9'h1FF, 1, 16'h0000);

    for (int i = 0; i < 400; i++) begin
      logic [15:0] sk;
      case ($urandom % 3)
        0: sk = 16'($urandom) & 16'($urandom) & 16'($urandom);
        1: sk = 16'($urandom);
        default: sk = 16'($urandom) | 16'($urandom);
      endcase
      apply_vec(($urandom % 8) != 0, 9'($urandom), 1'($urandom), sk);
    end
    finish_run();
  end
endmodule